// File: doc/BRIEF.md
# Framed Byte Serial Link Endpoint

This block is one end of a full-duplex, point-to-point serial link that uses one output wire and one input wire. Each byte offered on the transmit stream leaves the endpoint as a framed data packet. Each byte that arrives is handed to the receive stream and answered with a short acknowledge packet. A sender keeps at most one byte unacknowledged, so the flow control works per byte and needs no credit counter. Acknowledges share the output wire with outgoing data. They are slotted in between data packets and never split one.

The endpoint has two timing modes, chosen by a static control pin. In free-running mode a bit lasts `BIT_CYCLES` cycles of the system clock. The input is oversampled: a rising edge on an idle line opens a frame, and each later bit is sampled at its centre. In clocked mode an external bit clock paces the link. This is for links carried over a JTAG test port that stays parked in the data-shift state, with the output driving TDI, the input taken from TDO and the bit clock taken from TCK. In this mode each rising bit-clock edge exchanges exactly one bit in each direction. Both streams use valid/ready. The transmit side stalls through `tx_ready` while its one-byte holding register is full. The receive side holds `rx_valid` and `rx_data` unchanged until `rx_ready` is seen. A consumer that holds `rx_ready` low stops acknowledges from going out, and that throttles the far sender.

Top module: `sl_link`

## Requirements
- R1: A data packet on `link_out` is, in wire order, a 1, a 1, the eight data bits with bit 0 first, and then a 0.
- R2: An acknowledge packet is a 1 followed by a 0. A receiver classifies an incoming packet by the bit after its first 1: a 1 there means data and a 0 means acknowledge. A received acknowledge releases the local transmitter.
- R3: `tx_ready` is high exactly when the one-byte holding register is empty. A byte is taken on a cycle with `tx_valid` and `tx_ready` both high. No new data packet begins while an earlier data packet is still unacknowledged.
- R4: A received byte appears on `rx_data` with `rx_valid`, and both stay unchanged until the cycle in which `rx_ready` is high. The acknowledge for a byte goes out only once that byte has entered this output buffer. A second byte that arrives while the buffer is full is kept, and is neither acknowledged nor lost.
- R5: A pending acknowledge is never placed inside a data packet. At a packet boundary it is sent before any waiting data byte.
- R6: After reset `link_out` is 0, `rx_valid` is 0 and `tx_ready` is 1. Between packets the line rests at 0.
- R7: In free-running mode (`jtag_mode` = 0) every bit on `link_out` lasts `BIT_CYCLES` clock cycles. The receiver samples each bit near its centre, counted from the rising edge that starts the packet.
- R8: In clocked mode (`jtag_mode` = 1) `link_out` changes only right after a rising edge of `tck_in`, by one bit per edge. `link_in` is sampled at that same edge, and the link never leaves this exchange state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| jtag_mode | input | 1 | 1: paced by `tck_in`; 0: free-running bit timing |
| tck_in | input | 1 | External bit clock used in clocked mode (TCK) |
| link_in | input | 1 | Serial input line (TDO in clocked mode) |
| link_out | output | 1 | Serial output line (TDI in clocked mode) |
| tx_valid | input | 1 | Transmit byte offered |
| tx_ready | output | 1 | Holding register empty, byte can be taken |
| tx_data | input | DATA_W | Transmit byte |
| rx_valid | output | 1 | Received byte available |
| rx_ready | input | 1 | Consumer takes the received byte |
| rx_data | output | DATA_W | Received byte |

## Verification
The hard case is a byte that finishes arriving while the endpoint is partway through sending its own data packet. The acknowledge request is then raised in the middle of an outgoing frame. In clocked mode the bench starts an incoming frame, pushes a local byte four bit times later, and keeps both streams running so the incoming stop bit lands near the middle of the outgoing packet. The bench decodes the output wire bit by bit. It passes the case only if the outgoing data packet comes out whole with a correct stop bit and the acknowledge follows right after it. A second overlap is checked with two endpoints looped back in free-running mode: random bytes flow both ways while random back-pressure is applied.

// File: rtl/sl_pkg.sv
package sl_pkg;
  localparam int BYTE_W = 8;
  localparam int ACK_LEN = 2;

  typedef enum logic [1:0] {
    RX_IDLE,
    RX_KIND,
    RX_DATA,
    RX_STOP
  } rx_state_e;
endpackage

// File: rtl/sl_bitclk.sv
module sl_bitclk #(
  parameter int BIT_CYCLES = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic jtag_mode,
  input  logic tck_in,
  input  logic line_in,
  output logic tx_tick,
  output logic tck_rise,
  output logic line_s
);
  localparam int CW = $clog2(BIT_CYCLES + 1);

  logic [2:0]    tck_q;
  logic [1:0]    line_q;
  logic [CW-1:0] cnt;
  logic          free_tick;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tck_q  <= '0;
      line_q <= '0;
      cnt    <= '0;
    end else begin
      tck_q  <= {tck_q[1:0], tck_in};
      line_q <= {line_q[0], line_in};
      if (cnt == CW'(BIT_CYCLES - 1)) cnt <= '0;
      else                            cnt <= cnt + 1'b1;
    end
  end

  assign tck_rise  = tck_q[1] & ~tck_q[2];
  assign line_s    = line_q[1];
  assign free_tick = (cnt == CW'(BIT_CYCLES - 1));
  assign tx_tick   = jtag_mode ? tck_rise : free_tick;

  generate
    if (BIT_CYCLES > 1) begin : g_spacing
      // R7: free-running ticks are never adjacent
      assert_tick_spacing_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!jtag_mode && tx_tick) |=> !tx_tick);
    end
  endgenerate
endmodule

// File: rtl/sl_tx.sv
module sl_tx #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              tx_valid,
  output logic              tx_ready,
  input  logic [DATA_W-1:0] tx_data,
  input  logic              ack_req,
  input  logic              ack_seen,
  output logic              line_out
);
  localparam int FL = DATA_W + 3;
  localparam int LW = $clog2(FL + 1);

  logic              hold_full;
  logic [DATA_W-1:0] hold_data;
  logic              awaiting;
  logic              ack_pend;
  logic [FL-2:0]     sr;
  logic [LW-1:0]     left;
  logic              in_data;
  logic              start_ack, start_data, data_busy;

  assign tx_ready   = !hold_full;
  assign start_ack  = tick && (left == '0) && ack_pend;
  assign start_data = tick && (left == '0) && !ack_pend && hold_full && !awaiting;
  assign data_busy  = in_data && (left != '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hold_full <= 1'b0;
      hold_data <= '0;
      awaiting  <= 1'b0;
      ack_pend  <= 1'b0;
      sr        <= '0;
      left      <= '0;
      in_data   <= 1'b0;
      line_out  <= 1'b0;
    end else begin
      if (tx_valid && tx_ready) begin
        hold_full <= 1'b1;
        hold_data <= tx_data;
      end
      if (start_data) hold_full <= 1'b0;

      if (start_ack) ack_pend <= 1'b0;
      if (ack_req)   ack_pend <= 1'b1;

      if (ack_seen)   awaiting <= 1'b0;
      if (start_data) awaiting <= 1'b1;

      if (tick) begin
        if (left == '0) begin
          if (start_ack) begin
            line_out <= 1'b1;
            sr       <= '0;
            left     <= LW'(ACK_BITS_AFTER_FIRST);
            in_data  <= 1'b0;
          end else if (start_data) begin
            line_out <= 1'b1;
            sr       <= {1'b0, hold_data, 1'b1};
            left     <= LW'(FL - 1);
            in_data  <= 1'b1;
          end else begin
            line_out <= 1'b0;
            in_data  <= 1'b0;
          end
        end else begin
          line_out <= sr[0];
          sr       <= sr >> 1;
          left     <= left - 1'b1;
        end
      end
    end
  end

  localparam int ACK_BITS_AFTER_FIRST = sl_pkg::ACK_LEN - 1;

  // R5: an acknowledge request stays pending while a data packet is on the wire
  assert_ack_waits_frame_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (data_busy && ack_pend) |=> ack_pend);

  // R3: accepting a byte fills the holding register
  assert_hold_fills_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && tx_ready) |=> !tx_ready);

  // R3: no data packet starts while the previous one is unacknowledged
  assert_one_outstanding_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (awaiting && !ack_seen && tick && left == '0) |=> !(in_data && left == LW'(FL - 1)));
endmodule

// File: rtl/sl_rx.sv
module sl_rx #(
  parameter int DATA_W     = 8,
  parameter int BIT_CYCLES = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              jtag_mode,
  input  logic              tck_rise,
  input  logic              line_s,
  output logic              rx_valid,
  input  logic              rx_ready,
  output logic [DATA_W-1:0] rx_data,
  output logic              ack_req,
  output logic              ack_seen
);
  import sl_pkg::*;

  localparam int PW   = (BIT_CYCLES > 2) ? $clog2(BIT_CYCLES) : 1;
  localparam int HALF = (BIT_CYCLES / 2 > 0) ? BIT_CYCLES / 2 : 1;
  localparam int CW   = $clog2(DATA_W);

  rx_state_e         st;
  logic              line_prev;
  logic              armed;
  logic [PW-1:0]     phase;
  logic [CW-1:0]     cnt;
  logic [DATA_W-1:0] sr;
  logic              pend;
  logic [DATA_W-1:0] pend_data;
  logic              strobe, edge_up;

  assign edge_up = line_s && !line_prev;
  assign strobe  = jtag_mode ? tck_rise : (armed && phase == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st        <= RX_IDLE;
      line_prev <= 1'b0;
      armed     <= 1'b0;
      phase     <= '0;
      cnt       <= '0;
      sr        <= '0;
      pend      <= 1'b0;
      pend_data <= '0;
      rx_valid  <= 1'b0;
      rx_data   <= '0;
      ack_req   <= 1'b0;
      ack_seen  <= 1'b0;
    end else begin
      line_prev <= line_s;
      ack_req   <= 1'b0;
      ack_seen  <= 1'b0;

      if (!jtag_mode) begin
        if (!armed && st == RX_IDLE && edge_up) begin
          armed <= 1'b1;
          phase <= PW'(HALF - 1);
        end else if (armed) begin
          if (phase == '0) phase <= PW'(BIT_CYCLES - 1);
          else             phase <= phase - 1'b1;
        end
      end

      if (strobe) begin
        unique case (st)
          RX_IDLE: begin
            if (line_s) st <= RX_KIND;
            else        armed <= 1'b0;
          end
          RX_KIND: begin
            if (line_s) begin
              st  <= RX_DATA;
              cnt <= '0;
            end else begin
              ack_seen <= 1'b1;
              st       <= RX_IDLE;
              armed    <= 1'b0;
            end
          end
          RX_DATA: begin
            sr  <= {line_s, sr[DATA_W-1:1]};
            cnt <= cnt + 1'b1;
            if (cnt == CW'(DATA_W - 1)) st <= RX_STOP;
          end
          RX_STOP: begin
            st    <= RX_IDLE;
            armed <= 1'b0;
            if (!line_s) begin
              pend      <= 1'b1;
              pend_data <= sr;
            end
          end
          default: st <= RX_IDLE;
        endcase
      end

      if (rx_valid && rx_ready) rx_valid <= 1'b0;
      if (pend && !rx_valid) begin
        rx_valid <= 1'b1;
        rx_data  <= pend_data;
        pend     <= 1'b0;
        ack_req  <= 1'b1;
      end
    end
  end

  // R4: an offered byte is held steady until taken
  assert_rx_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && !rx_ready) |=> (rx_valid && $stable(rx_data)));

  // R4: an acknowledge is requested only as a byte enters the output buffer
  assert_ack_on_fill_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ack_req |-> rx_valid);
endmodule

// File: rtl/sl_link.sv
module sl_link #(
  parameter int DATA_W     = sl_pkg::BYTE_W,
  parameter int BIT_CYCLES = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              jtag_mode,
  input  logic              tck_in,
  input  logic              link_in,
  output logic              link_out,
  input  logic              tx_valid,
  output logic              tx_ready,
  input  logic [DATA_W-1:0] tx_data,
  output logic              rx_valid,
  input  logic              rx_ready,
  output logic [DATA_W-1:0] rx_data
);
  logic tx_tick, tck_rise, line_s, ack_req, ack_seen;

  sl_bitclk #(.BIT_CYCLES(BIT_CYCLES)) u_clk (
    .clk(clk), .rst_n(rst_n), .jtag_mode(jtag_mode), .tck_in(tck_in),
    .line_in(link_in), .tx_tick(tx_tick), .tck_rise(tck_rise), .line_s(line_s)
  );

  sl_tx #(.DATA_W(DATA_W)) u_tx (
    .clk(clk), .rst_n(rst_n), .tick(tx_tick), .tx_valid(tx_valid),
    .tx_ready(tx_ready), .tx_data(tx_data), .ack_req(ack_req),
    .ack_seen(ack_seen), .line_out(link_out)
  );

  sl_rx #(.DATA_W(DATA_W), .BIT_CYCLES(BIT_CYCLES)) u_rx (
    .clk(clk), .rst_n(rst_n), .jtag_mode(jtag_mode), .tck_rise(tck_rise),
    .line_s(line_s), .rx_valid(rx_valid), .rx_ready(rx_ready),
    .rx_data(rx_data), .ack_req(ack_req), .ack_seen(ack_seen)
  );

  // R8: in clocked mode the output moves only after a bit-clock rise
  assert_clocked_out_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (jtag_mode && !tck_rise) |=> $stable(link_out));
endmodule

// File: tb/sim_sl_link.sv
module sim_sl_link;
  localparam int CLK_HALF = 5;
  localparam int BC = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic jmode = 1'b1;
  logic b_tck = 1'b0;
  logic b_in = 1'b0;
  logic u0_in, u0_out, u1_out;
  logic u0_txv = 1'b0, u0_txr, u0_rxv, u0_rxr = 1'b0;
  logic u1_txv = 1'b0, u1_txr, u1_rxv, u1_rxr = 1'b0;
  logic [7:0] u0_txd = '0, u0_rxd, u1_txd = '0, u1_rxd;

  int n_chk = 0, n_bad = 0;
  int ev[$];
  int pst = 0, pcnt = 0;
  logic [7:0] psr;
  logic [7:0] exp01[$];
  logic [7:0] exp10[$];

  always #CLK_HALF clk = ~clk;
  assign u0_in = jmode ? b_in : u1_out;

  sl_link #(.BIT_CYCLES(BC)) u0 (
    .clk(clk), .rst_n(rst_n), .jtag_mode(jmode), .tck_in(b_tck), .link_in(u0_in),
    .link_out(u0_out), .tx_valid(u0_txv), .tx_ready(u0_txr), .tx_data(u0_txd),
    .rx_valid(u0_rxv), .rx_ready(u0_rxr), .rx_data(u0_rxd)
  );

  sl_link #(.BIT_CYCLES(BC)) u1 (
    .clk(clk), .rst_n(rst_n), .jtag_mode(1'b0), .tck_in(1'b0), .link_in(u0_out),
    .link_out(u1_out), .tx_valid(u1_txv), .tx_ready(u1_txr), .tx_data(u1_txd),
    .rx_valid(u1_rxv), .rx_ready(u1_rxr), .rx_data(u1_rxd)
  );

  task automatic check(input bit ok, input string req, input int act, input int expv);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  function automatic logic [10:0] wire_bits(input logic [7:0] d);
    return {1'b0, d, 2'b11};
  endfunction

  // one clocked-mode bit exchange; the bench decodes what u0 sends
  task automatic pulse(input logic bit_in, output logic bit_out);
    @(negedge clk);
    b_in = bit_in;
    repeat (2) @(negedge clk);
    b_tck = 1'b1;
    repeat (6) @(negedge clk);
    b_tck = 1'b0;
    repeat (6) @(negedge clk);
    bit_out = u0_out;
    case (pst)
      0: if (bit_out) pst = 1;
      1: if (bit_out) begin pst = 2; pcnt = 0; end
         else begin ev.push_back(256); pst = 0; end
      2: begin psr[pcnt] = bit_out; pcnt++; if (pcnt == 8) pst = 3; end
      default: begin
        check(bit_out == 1'b0, "R1 stop bit", bit_out, 0);
        ev.push_back(int'(psr));
        pst = 0;
      end
    endcase
  endtask

  task automatic idle_pulses(input int n);
    logic o;
    for (int i = 0; i < n; i++) pulse(1'b0, o);
  endtask

  task automatic send_frame(input logic [7:0] d);
    logic o;
    logic [10:0] w;
    w = wire_bits(d);
    for (int i = 0; i < 11; i++) pulse(w[i], o);
  endtask

  task automatic send_ack();
    logic o;
    pulse(1'b1, o);
    pulse(1'b0, o);
  endtask

  task automatic push0(input logic [7:0] d);
    @(negedge clk);
    while (!u0_txr) @(negedge clk);
    u0_txv = 1'b1;
    u0_txd = d;
    @(negedge clk);
    u0_txv = 1'b0;
  endtask

  task automatic expect_ev(input int v, input string req);
    if (ev.size() > 0) begin
      int g;
      g = ev.pop_front();
      check(g == v, req, g, v);
    end else check(1'b0, req, -1, v);
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic take0();
    @(negedge clk);
    u0_rxr = 1'b1;
    @(negedge clk);
    u0_rxr = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    check(1'b0, "watchdog", 0, 1);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin : main
    logic o;
    logic [10:0] got;
    int ones;
    do_reset();
    @(negedge clk);
    // R6 reset state
    check(u0_out == 1'b0, "R6 link_out", u0_out, 0);
    check(u0_rxv == 1'b0, "R6 rx_valid", u0_rxv, 0);
    check(u0_txr == 1'b1, "R6 tx_ready", u0_txr, 1);

    // R1/R8: data packet shape, one bit per bit-clock edge
    push0(8'hA5);
    for (int i = 0; i < 11; i++) begin pulse(1'b0, o); got[i] = o; end
    check(got == wire_bits(8'hA5), "R1 R8 frame bits", got, wire_bits(8'hA5));
    idle_pulses(3);
    expect_ev(8'hA5, "R1 decoded byte");

    // R3: no second packet until an ack arrives
    push0(8'h3C);
    @(negedge clk);
    check(u0_txr == 1'b0, "R3 holding full", u0_txr, 0);
    ones = 0;
    for (int i = 0; i < 20; i++) begin pulse(1'b0, o); ones += o; end
    check(ones == 0, "R3 R6 line idle while awaiting", ones, 0);
    check(ev.size() == 0, "R3 no packet", ev.size(), 0);
    send_ack();                        // R2 ack releases transmitter
    idle_pulses(14);
    expect_ev(8'h3C, "R2 R3 byte after ack");
    send_ack();
    idle_pulses(2);

    // R4: receive path, ack timing and back-pressure
    send_frame(8'h5A);
    idle_pulses(4);
    check(u0_rxv == 1'b1, "R4 rx_valid", u0_rxv, 1);
    check(u0_rxd == 8'h5A, "R4 rx_data", u0_rxd, 8'h5A);
    expect_ev(256, "R2 R4 ack sent");
    send_frame(8'hC3);
    idle_pulses(15);
    check(ev.size() == 0, "R4 no ack while full", ev.size(), 0);
    check(u0_rxd == 8'h5A, "R4 data held", u0_rxd, 8'h5A);
    take0();
    check(u0_rxv == 1'b1 && u0_rxd == 8'hC3, "R4 second byte kept", u0_rxd, 8'hC3);
    idle_pulses(4);
    expect_ev(256, "R4 ack after drain");
    take0();
    check(u0_rxv == 1'b0, "R4 drained", u0_rxv, 0);

    // R5: byte completes while u0 is mid packet
    begin
      logic [10:0] w;
      w = wire_bits(8'h81);
      for (int i = 0; i < 4; i++) pulse(w[i], o);
      push0(8'h0F);
      for (int i = 4; i < 11; i++) pulse(w[i], o);
    end
    idle_pulses(16);
    expect_ev(8'h0F, "R5 data packet intact");
    expect_ev(256, "R5 ack after packet");
    check(u0_rxd == 8'h81, "R5 byte received", u0_rxd, 8'h81);
    send_ack();
    take0();

    // free-running loopback between u0 and u1
    jmode = 1'b0;
    do_reset();
    push0(8'h00);
    exp01.push_back(8'h00);
    while (u0_out !== 1'b1) @(negedge clk);
    ones = 0;
    while (u0_out === 1'b1) begin ones++; @(negedge clk); end
    check(ones == 2 * BC, "R7 start bits length", ones, 2 * BC);

    void'($urandom(32'd4242));
    for (int i = 0; i < 30; i++) begin
      exp01.push_back(8'($urandom));
      exp10.push_back(8'($urandom));
    end
    fork
      begin
        for (int i = 1; i < 31; i++) push0(exp01[i]);
      end
      begin
        for (int i = 0; i < 30; i++) begin
          @(negedge clk);
          while (!u1_txr) @(negedge clk);
          u1_txv = 1'b1;
          u1_txd = exp10[i];
          @(negedge clk);
          u1_txv = 1'b0;
        end
      end
      begin
        int k = 0;
        while (k < 31) begin
          @(negedge clk);
          u1_rxr = ($urandom % 4) != 0;
          if (u1_rxr && u1_rxv) begin
            check(u1_rxd == exp01[k], "R7 u0->u1 byte", u1_rxd, exp01[k]);
            k++;
          end
        end
        @(negedge clk);
        u1_rxr = 1'b0;
      end
      begin
        int k = 0;
        while (k < 30) begin
          @(negedge clk);
          u0_rxr = ($urandom % 3) != 0;
          if (u0_rxr && u0_rxv) begin
            check(u0_rxd == exp10[k], "R7 u1->u0 byte", u0_rxd, exp10[k]);
            k++;
          end
        end
        @(negedge clk);
        u0_rxr = 1'b0;
      end
    join
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule